// File: doc/BRIEF.md
# System Timer with Per-Processor Mode Control

This block is the chip-level counter/timer. A tick input advances a counter held in bits 30:9 of the counter word. When the incremented count matches the programmed limit, the count returns to zero, a sticky reached flag is set and the system interrupt is raised. Software programs the limit in two ways. One write restarts the count from zero. The other replaces the limit and leaves the running count as it is. Reading the limit acknowledges the interrupt.

The block also holds a mode vector with one bit per processor. A 1 bit puts that processor's local timer into free-running user mode, and a 0 bit leaves it in interrupt-generating limit mode. The vector goes out on `cpuMode`. Each write to the mode register also produces single-cycle pulses. `cpuClear` marks every processor whose written bit is 1; that processor must drop its interrupt and take the maximum limit. `cpuRestart` marks every processor whose bit changed; that processor must stop, reload from zero and run again. The local timers themselves sit outside this block.

The register bus is word indexed: 0 is the resetting limit, 1 is the counter, 2 is the non-resetting limit, 3 is start/stop and 4 is the mode vector. Read data is registered.

Top module: `systimer_modectl`

## Requirements
- R1: After reset, `sysIrq`, `cpuMode`, `cpuClear` and `cpuRestart` are 0, index 0 reads 0x7FFFFE00 and index 1 reads 0.
- R2: A limit write keeps only `wrData[30:9]`. A written field of zero stores the maximum 0x3FFFFF. Reading index 0 returns the limit in bits 30:9, with all other bits 0.
- R3: A write to index 0 sets the count to 0 and lowers `sysIrq` on the next cycle, and leaves the reached flag alone. A tick in that same cycle is discarded.
- R4: Each cycle with `tick` high increments the count, which reads back in bits 30:9 of index 1. When the incremented value equals the limit, the count becomes 0, and the reached flag (bit 31 of the index 1 read) and `sysIrq` are set. Reading index 1 does not clear the flag.
- R5: Reading index 0 clears the reached flag and `sysIrq`. If a wrap happens in the same cycle, the wrap wins and both stay set.
- R6: A write to index 2 replaces the limit without changing the count, the flag or `sysIrq`. A tick in the same cycle is compared against the old limit.
- R7: Writes to index 1 and index 3 change no state. Reads of indices 2, 3, 5, 6 and 7 return 0.
- R8: A write to index 4 stores `wrData[N_CPU-1:0]` into `cpuMode`, which otherwise holds. Reading index 4 returns the vector zero-extended.
- R9: A mode write makes `cpuClear` equal to the written low `N_CPU` bits for exactly one cycle; it is 0 otherwise.
- R10: A mode write makes `cpuRestart` equal to the written bits XOR the previous mode for exactly one cycle; it is 0 otherwise.
- R11: `rdData` is updated on the clock edge that samples `rdEn` and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one count step per cycle |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word index of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| sysIrq | output | 1 | System timer interrupt |
| cpuMode | output | N_CPU | Per-processor user-mode select |
| cpuClear | output | N_CPU | One-cycle clear-interrupt / max-limit pulses |
| cpuRestart | output | N_CPU | One-cycle stop-reload-run pulses |

## Verification
The hardest cases are collisions with a wrap cycle: a tick that completes the count while a limit write, or a limit read, lands in the same cycle. The stimulus first programs a small limit and runs the count to exactly one step short of it with a counted burst of ticks. It then raises `tick` together with the bus strobe on the same edge. The reference model scores the result on every clock.

// File: rtl/systimer_pkg.sv
package systimer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] IDX_LIMIT = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_NORST = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_RUN   = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_MODE  = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic limitWr;   // resetting limit write
    logic noRstWr;   // non-resetting limit write
    logic limitRd;   // limit read (acknowledge)
  } tmrStrobe_t;
endpackage

// File: rtl/systimer_dp.sv
module systimer_dp
  import systimer_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  tmrStrobe_t       st,
  input  logic [CNT_W-1:0] limitIn,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] limitQ,
  output logic             reachedQ,
  output logic             irqQ
);
  logic [CNT_W-1:0] countInc;
  logic [CNT_W-1:0] limitNew;
  logic             wrapHit;

  assign countInc = countQ + 1'b1;
  assign wrapHit  = tick && (countInc == limitQ);
  assign limitNew = (limitIn == '0) ? '1 : limitIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ   <= '0;
      limitQ   <= '1;
      reachedQ <= 1'b0;
      irqQ     <= 1'b0;
    end else if (st.limitWr) begin
      limitQ <= limitNew;
      countQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (st.noRstWr) limitQ <= limitNew;
      if (tick) countQ <= wrapHit ? '0 : countInc;
      if (wrapHit) begin
        reachedQ <= 1'b1;
        irqQ     <= 1'b1;
      end else if (st.limitRd) begin
        reachedQ <= 1'b0;
        irqQ     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/systimer_ctrl.sv
module systimer_ctrl
  import systimer_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int CNT_W   = 22,
  parameter int CNT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_CPU-1:0]  modeIn,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [CNT_W-1:0]  limitQ,
  input  logic              reachedQ,
  output tmrStrobe_t        st,
  output logic [DATA_W-1:0] rdData,
  output logic [N_CPU-1:0]  cpuMode,
  output logic [N_CPU-1:0]  cpuClear,
  output logic [N_CPU-1:0]  cpuRestart
);
  logic              modeWr;
  logic [DATA_W-1:0] rdNext;

  assign st.limitWr = wrEn && (addr == IDX_LIMIT);
  assign st.noRstWr = wrEn && (addr == IDX_NORST);
  assign st.limitRd = rdEn && (addr == IDX_LIMIT);
  assign modeWr     = wrEn && (addr == IDX_MODE);

  always_comb begin
    rdNext = '0;
    case (addr)
      IDX_LIMIT: rdNext[CNT_LSB +: CNT_W] = limitQ;
      IDX_COUNT: begin
        rdNext[CNT_LSB +: CNT_W] = countQ;
        rdNext[DATA_W-1]         = reachedQ;
      end
      IDX_MODE:  rdNext[N_CPU-1:0] = cpuMode;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData     <= '0;
      cpuMode    <= '0;
      cpuClear   <= '0;
      cpuRestart <= '0;
    end else begin
      if (rdEn) rdData <= rdNext;
      cpuClear   <= modeWr ? modeIn : '0;
      cpuRestart <= modeWr ? (modeIn ^ cpuMode) : '0;
      if (modeWr) cpuMode <= modeIn;
    end
  end
endmodule

// File: rtl/systimer_modectl.sv
module systimer_modectl
  import systimer_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int CNT_W   = 22,
  parameter int CNT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sysIrq,
  output logic [N_CPU-1:0]  cpuMode,
  output logic [N_CPU-1:0]  cpuClear,
  output logic [N_CPU-1:0]  cpuRestart
);
  tmrStrobe_t       st;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] limitQ;
  logic             reachedQ;

  systimer_ctrl #(.N_CPU(N_CPU), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .modeIn(wrData[N_CPU-1:0]), .countQ(countQ), .limitQ(limitQ),
    .reachedQ(reachedQ), .st(st), .rdData(rdData), .cpuMode(cpuMode),
    .cpuClear(cpuClear), .cpuRestart(cpuRestart)
  );

  systimer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .tick(tick), .st(st),
    .limitIn(wrData[CNT_LSB +: CNT_W]), .countQ(countQ), .limitQ(limitQ),
    .reachedQ(reachedQ), .irqQ(sysIrq)
  );
endmodule

// File: rtl/systimer_modectl_chk.sv
module systimer_modectl_chk #(
  parameter int N_CPU = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic [31:0]      wrData,
  input logic             sysIrq,
  input logic [N_CPU-1:0] cpuMode,
  input logic [N_CPU-1:0] cpuClear,
  input logic [N_CPU-1:0] cpuRestart
);
  // R3
  limit_wr_lowers_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 3'd0) |=> !sysIrq);

  // R4
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sysIrq) |-> $past(tick));

  // R8
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 3'd4) |=> (cpuMode == $past(wrData[N_CPU-1:0])));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && addr == 3'd4) |=> $stable(cpuMode));

  // R9
  clear_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuClear != '0) |-> $past(wrEn && addr == 3'd4));

  // R10
  restart_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuRestart != '0) |-> $past(wrEn && addr == 3'd4));
endmodule

bind systimer_modectl systimer_modectl_chk #(.N_CPU(N_CPU)) uChk (
  .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .sysIrq(sysIrq), .cpuMode(cpuMode),
  .cpuClear(cpuClear), .cpuRestart(cpuRestart)
);

// File: tb/tb_systimer_modectl.sv
module tb_systimer_modectl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sysIrq;
  logic [N-1:0] cpuMode, cpuClear, cpuRestart;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  systimer_modectl #(.N_CPU(N)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .sysIrq(sysIrq),
    .cpuMode(cpuMode), .cpuClear(cpuClear), .cpuRestart(cpuRestart)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [21:0]  mCnt, mLim, mNext, mNew;
  logic         mReach, mIrq, mWrap;
  logic [N-1:0] mMode, mClr, mRst;
  logic [31:0]  mRd;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mLim = '1; mReach = 0; mIrq = 0;
      mMode = 0; mClr = 0; mRst = 0; mRd = 0;
    end else begin
      if (rdEn) begin
        case (addr)
          3'd0: mRd = {1'b0, mLim, 9'b0};
          3'd1: mRd = {mReach, mCnt, 9'b0};
          3'd4: mRd = {{(32-N){1'b0}}, mMode};
          default: mRd = 0;
        endcase
      end
      mClr = 0; mRst = 0;
      if (wrEn && addr == 3'd4) begin
        mClr = wrData[N-1:0];
        mRst = wrData[N-1:0] ^ mMode;
        mMode = wrData[N-1:0];
      end
      mNew = (wrData[30:9] == 0) ? '1 : wrData[30:9];
      if (wrEn && addr == 3'd0) begin
        mLim = mNew; mCnt = 0; mIrq = 0;
      end else begin
        mNext = mCnt + 22'd1;
        mWrap = tick && (mNext == mLim);
        if (tick) mCnt = mWrap ? 22'd0 : mNext;
        if (wrEn && addr == 3'd2) mLim = mNew;
        if (mWrap) begin mReach = 1; mIrq = 1; end
        else if (rdEn && addr == 3'd0) begin mReach = 0; mIrq = 0; end
      end
    end
    #2;
    if (!rst) begin
      chk("R4 sysIrq", {31'b0, sysIrq}, {31'b0, mIrq});
      chk("R8 cpuMode", {28'b0, cpuMode}, {28'b0, mMode});
      chk("R9 cpuClear", {28'b0, cpuClear}, {28'b0, mClr});
      chk("R10 cpuRestart", {28'b0, cpuRestart}, {28'b0, mRst});
      chk("R11 rdData", rdData, mRd);
    end
  end

  // Tasks: enter and leave at a negedge
  task automatic busWr(logic [2:0] a, logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic busRd(logic [2:0] a, output logic [31:0] v);
    rdEn = 1; addr = a;
    @(negedge clk);
    rdEn = 0;
    v = rdData;
  endtask

  task automatic ticks(int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, sysIrq}, 0);
    chk("R1 mode", {28'b0, cpuMode}, 0);
    busRd(3'd0, v); chk("R1 limit", v, 32'h7FFFFE00);
    busRd(3'd1, v); chk("R1 count", v, 0);
    // R2 masking and zero limit
    busWr(3'd0, 32'hFFFFFFFF); busRd(3'd0, v); chk("R2 mask", v, 32'h7FFFFE00);
    busWr(3'd0, 32'h0);        busRd(3'd0, v); chk("R2 zero", v, 32'h7FFFFE00);
    busWr(3'd0, (5 << 9) | 32'h1FF); busRd(3'd0, v); chk("R2 small", v, 32'h00000A00);
    // R4 counting and wrap
    ticks(3); busRd(3'd1, v); chk("R4 count", v, 3 << 9);
    ticks(2);
    chk("R4 irq", {31'b0, sysIrq}, 1);
    busRd(3'd1, v); chk("R4 reached", v, 32'h80000000);
    busRd(3'd1, v); chk("R4 sticky", v, 32'h80000000);
    // R5 acknowledge
    busRd(3'd0, v);
    chk("R5 irq cleared", {31'b0, sysIrq}, 0);
    busRd(3'd1, v); chk("R5 reached cleared", v, 0);
    // R6 non-resetting limit
    ticks(2);
    busWr(3'd2, 8 << 9);
    busRd(3'd1, v); chk("R6 count kept", v, 2 << 9);
    busRd(3'd0, v); chk("R6 limit", v, 8 << 9);
    ticks(6);
    chk("R6 wrap new limit", {31'b0, sysIrq}, 1);
    // R3 limit write with tick in same cycle
    tick = 1; busWr(3'd0, 8 << 9); tick = 0;
    chk("R3 irq low", {31'b0, sysIrq}, 0);
    busRd(3'd1, v); chk("R3 count zero", v, 32'h80000000);
    busRd(3'd0, v);
    // R5 wrap and acknowledge in same cycle
    ticks(7);
    tick = 1; busRd(3'd0, v); tick = 0;
    chk("R5 wrap wins", {31'b0, sysIrq}, 1);
    busRd(3'd1, v); chk("R5 reached kept", v, 32'h80000000);
    busRd(3'd0, v);
    // R7 ignored writes and empty reads
    busWr(3'd1, 32'h12345600);
    busWr(3'd3, 32'h1);
    busRd(3'd1, v); chk("R7 count untouched", v, 0);
    busRd(3'd0, v); chk("R7 limit untouched", v, 8 << 9);
    busRd(3'd3, v); chk("R7 read idx3", v, 0);
    busRd(3'd2, v); chk("R7 read idx2", v, 0);
    busRd(3'd6, v); chk("R7 read idx6", v, 0);
    // R8..R10 mode register
    busWr(3'd4, 32'hFFFFFFF5);
    chk("R9 clear", {28'b0, cpuClear}, 32'h5);
    chk("R10 restart", {28'b0, cpuRestart}, 32'h5);
    busRd(3'd4, v); chk("R8 mode read", v, 32'h5);
    chk("R9 clear gone", {28'b0, cpuClear}, 0);
    busWr(3'd4, 32'h6);
    chk("R9 clear2", {28'b0, cpuClear}, 32'h6);
    chk("R10 restart2", {28'b0, cpuRestart}, 32'h3);
    busWr(3'd4, 32'h6);
    chk("R10 no change", {28'b0, cpuRestart}, 0);
    chk("R8 mode", {28'b0, cpuMode}, 32'h6);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule